// File: doc/BRIEF.md
# SMBus Target Address-Match Responder

This block watches a two-wire SMBus segment as a target device. It samples the clock and data lines into the system clock domain and detects start, repeated-start and stop conditions. After a start it collects a 7-bit address and compares it with a programmable own-address input. On a match it pulls the data line low for the acknowledge and claims the transaction. A mismatch leaves the line released and the block waits for the next start.

Once a transaction is claimed, the block follows a fixed schedule of bit positions. Position 1 is the start. Positions 2 to 8 carry the address, position 9 the direction bit, and position 10 the acknowledge. The command byte follows with its acknowledge at position 19. After that come either write data bytes or a repeated start at position 20. The second address phase carries the address at 21 to 27, the direction bit at 28 and the acknowledge at 29, and read bytes follow. The direction bit is never checked. The block assumes the sequence is well formed, so a read-direction first address is still claimed.

The received command and write bytes appear on parallel outputs with a one-cycle strobe. A read-data request strobe asks the surrounding logic to present the next byte on the read-data input before the next falling clock edge.

Top module: `smbt_responder`

## Requirements
- R1: After reset the data-line pull-down is off, and the command, write and read-request strobes are low.
- R2: After a start, the block pulls the data line low during bit position 10 exactly when the seven bits at positions 2 to 8 (MSB first) equal `ownAddr`, whatever the direction bit at position 9.
- R3: When the address does not match, the pull-down stays off for the rest of the transaction and no strobe is raised until the next start.
- R4: In a claimed transaction, the eight bits at positions 11 to 18 (MSB first) appear on `cmdByte` with a one-cycle `cmdStb`, and position 19 is acknowledged.
- R5: Each further 8-bit byte that is not preceded by a repeated start appears on `wrByte` with a one-cycle `wrStb` and is acknowledged.
- R6: A repeated start right after the command acknowledge opens the second address phase. A matching address there is acknowledged at position 29 whatever the direction bit at 28, and `rdReq` pulses once.
- R7: After the second acknowledge, the block drives `rdData` MSB first, sampled at the falling clock edge that ends position 29. It pulls the line low for 0 bits and releases it for 1 bits.
- R8: A master acknowledge (data low) after a read byte raises `rdReq` again and sends the next byte. A master not-acknowledge releases the line and ends the read.
- R9: A stop condition at any point releases the line, discards a partly received byte without a strobe, and returns the block to idle.
- R10: The pull-down changes state only while the clock line is low.
- R11: A mismatching address in the second address phase is not acknowledged and raises no `rdReq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pin |
| sdaIn | input | 1 | Bus data line as seen at the pin |
| ownAddr | input | 7 | Address this target answers to |
| rdData | input | 8 | Byte to send in the next read slot |
| sdaOeLow | output | 1 | High pulls the data line low (open-drain) |
| cmdByte | output | 8 | Last received command byte |
| cmdStb | output | 1 | One-cycle pulse when cmdByte updates |
| wrByte | output | 8 | Last received write data byte |
| wrStb | output | 1 | One-cycle pulse when wrByte updates |
| rdReq | output | 1 | One-cycle request for the next read byte |

## Verification
The bench sweeps every 7-bit address against a fixed own address, with the direction bit varied. A comparator that looked at the direction bit would miss the read-direction match, and one that compared the wrong bits would acknowledge a neighbour. It also covers a second-phase address with the direction bit cleared, and a second-phase mismatch. A block that treated the repeated start as a fresh transaction would ask for no read data. One that ignored the second compare would drive bytes onto a bus it does not own. A stop in the middle of the command byte checks that a partial byte raises no strobe and that the next transaction still works. A two-byte read ended by a not-acknowledge checks the MSB-first order, the request for the follow-on byte, and that the line is let go afterwards.

// File: rtl/smbt_pkg.sv
package smbt_pkg;
  localparam int ADDR_W    = 7;
  localparam int BYTE_BITS = 8;
  localparam int CNT_W     = $clog2(BYTE_BITS + 1);

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_CMD, ST_CMD_ACK, ST_WDATA, ST_WDATA_ACK,
    ST_RADDR, ST_RADDR_ACK, ST_RDATA, ST_MACK
  } smbtState_e;

  typedef struct packed {
    logic shiftIn;   // sample one receive bit
    logic loadCmd;   // publish command byte
    logic loadWr;    // publish write byte
    logic loadTx;    // take rdData and drive its MSB
    logic shiftTx;   // drive next transmit bit
    logic driveAck;  // pull line low for acknowledge
    logic relSda;    // release line
    logic reqRd;     // ask for next read byte
  } smbtCtrl_t;
endpackage

// File: rtl/smbt_datapath.sv
module smbt_datapath
  import smbt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sclIn,
  input  logic                 sdaIn,
  input  logic [ADDR_W-1:0]    ownAddr,
  input  logic [BYTE_BITS-1:0] rdData,
  input  smbtCtrl_t            ctrl,
  output logic                 sclRise,
  output logic                 sclFall,
  output logic                 startDet,
  output logic                 stopDet,
  output logic                 sdaBit,
  output logic                 addrHit,
  output logic                 sdaOeLow,
  output logic [BYTE_BITS-1:0] cmdByte,
  output logic                 cmdStb,
  output logic [BYTE_BITS-1:0] wrByte,
  output logic                 wrStb,
  output logic                 rdReq
);
  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclS, sdaS, sclQ, sdaQ;

  // Line synchronizers; idle bus level is high
  generate
    if (SYNC_STAGES == 1) begin : gSync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclPipe <= '1;
          sdaPipe <= '1;
        end else begin
          sclPipe <= sclIn;
          sdaPipe <= sdaIn;
        end
      end
    end else begin : gSyncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclPipe <= '1;
          sdaPipe <= '1;
        end else begin
          sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
          sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
        end
      end
    end
  endgenerate

  assign sclS = sclPipe[SYNC_STAGES-1];
  assign sdaS = sdaPipe[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclQ <= 1'b1;
      sdaQ <= 1'b1;
    end else begin
      sclQ <= sclS;
      sdaQ <= sdaS;
    end
  end

  assign sclRise  = sclS & ~sclQ;
  assign sclFall  = ~sclS & sclQ;
  assign startDet = sclS & sclQ & sdaQ & ~sdaS;
  assign stopDet  = sclS & sclQ & ~sdaQ & sdaS;
  assign sdaBit   = sdaS;

  // Receive shifter and address compare (direction bit in bit 0 is ignored)
  logic [BYTE_BITS-1:0] rxShift;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             rxShift <= '0;
    else if (ctrl.shiftIn) rxShift <= {rxShift[BYTE_BITS-2:0], sdaS};
  end
  assign addrHit = (rxShift[BYTE_BITS-1:1] == ownAddr);

  // Transmit shifter and open-drain pull-down
  logic [BYTE_BITS-1:0] txShift;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift  <= '0;
      sdaOeLow <= 1'b0;
    end else if (ctrl.driveAck) begin
      sdaOeLow <= 1'b1;
    end else if (ctrl.loadTx) begin
      txShift  <= {rdData[BYTE_BITS-2:0], 1'b0};
      sdaOeLow <= ~rdData[BYTE_BITS-1];
    end else if (ctrl.shiftTx) begin
      txShift  <= {txShift[BYTE_BITS-2:0], 1'b0};
      sdaOeLow <= ~txShift[BYTE_BITS-1];
    end else if (ctrl.relSda) begin
      sdaOeLow <= 1'b0;
    end
  end

  // Published bytes and strobes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdByte <= '0;
      wrByte  <= '0;
      cmdStb  <= 1'b0;
      wrStb   <= 1'b0;
      rdReq   <= 1'b0;
    end else begin
      cmdStb <= ctrl.loadCmd;
      wrStb  <= ctrl.loadWr;
      rdReq  <= ctrl.reqRd;
      if (ctrl.loadCmd) cmdByte <= rxShift;
      if (ctrl.loadWr)  wrByte  <= rxShift;
    end
  end

  AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (sdaOeLow != $past(sdaOeLow)) |-> (!$past(sclS) || $past(stopDet) || $past(startDet))); // R10
  AST_RELEASE_ON_STOP: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> !sdaOeLow); // R9
  AST_CMD_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.loadCmd |=> (cmdStb && cmdByte == $past(rxShift))); // R4
  AST_RD_MSB_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.loadTx |=> (sdaOeLow == !$past(rdData[BYTE_BITS-1]))); // R7
endmodule

// File: rtl/smbt_control.sv
module smbt_control
  import smbt_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclRise,
  input  logic      sclFall,
  input  logic      startDet,
  input  logic      stopDet,
  input  logic      sdaBit,
  input  logic      addrHit,
  output smbtCtrl_t ctrl
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_BITS);

  smbtState_e st, stNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic gotData, gotDataNext;
  logic ackSeen, ackSeenNext;

  always_comb begin
    ctrl        = '0;
    stNext      = st;
    cntNext     = cnt;
    gotDataNext = gotData;
    ackSeenNext = ackSeen;
    if (stopDet) begin
      stNext      = ST_IDLE;
      cntNext     = '0;
      ctrl.relSda = 1'b1;
    end else if (startDet) begin
      // Repeated start right after the command acknowledge opens the read phase
      stNext      = (st == ST_WDATA && !gotData) ? ST_RADDR : ST_ADDR;
      cntNext     = '0;
      ctrl.relSda = 1'b1;
    end else begin
      case (st)
        ST_ADDR, ST_CMD, ST_WDATA, ST_RADDR: begin
          if (sclRise && cnt != FULL) begin
            ctrl.shiftIn = 1'b1;
            cntNext      = cnt + 1'b1;
          end else if (sclFall && cnt == FULL) begin
            cntNext = '0;
            case (st)
              ST_ADDR: begin
                if (addrHit) begin
                  ctrl.driveAck = 1'b1;
                  stNext        = ST_ADDR_ACK;
                end else begin
                  ctrl.relSda = 1'b1;
                  stNext      = ST_IDLE;
                end
              end
              ST_RADDR: begin
                if (addrHit) begin
                  ctrl.driveAck = 1'b1;
                  ctrl.reqRd    = 1'b1;
                  stNext        = ST_RADDR_ACK;
                end else begin
                  ctrl.relSda = 1'b1;
                  stNext      = ST_IDLE;
                end
              end
              ST_CMD: begin
                ctrl.loadCmd  = 1'b1;
                ctrl.driveAck = 1'b1;
                stNext        = ST_CMD_ACK;
              end
              default: begin
                ctrl.loadWr   = 1'b1;
                ctrl.driveAck = 1'b1;
                gotDataNext   = 1'b1;
                stNext        = ST_WDATA_ACK;
              end
            endcase
          end
        end
        ST_ADDR_ACK: begin
          if (sclFall) begin
            ctrl.relSda = 1'b1;
            stNext      = ST_CMD;
          end
        end
        ST_CMD_ACK: begin
          if (sclFall) begin
            ctrl.relSda = 1'b1;
            gotDataNext = 1'b0;
            stNext      = ST_WDATA;
          end
        end
        ST_WDATA_ACK: begin
          if (sclFall) begin
            ctrl.relSda = 1'b1;
            stNext      = ST_WDATA;
          end
        end
        ST_RADDR_ACK: begin
          if (sclFall) begin
            ctrl.loadTx = 1'b1;
            cntNext     = CNT_W'(1);
            stNext      = ST_RDATA;
          end
        end
        ST_RDATA: begin
          if (sclFall) begin
            if (cnt != FULL) begin
              ctrl.shiftTx = 1'b1;
              cntNext      = cnt + 1'b1;
            end else begin
              ctrl.relSda = 1'b1;
              cntNext     = '0;
              stNext      = ST_MACK;
            end
          end
        end
        ST_MACK: begin
          if (sclRise) begin
            ackSeenNext = ~sdaBit;
            ctrl.reqRd  = ~sdaBit;
          end else if (sclFall) begin
            if (ackSeen) begin
              ctrl.loadTx = 1'b1;
              cntNext     = CNT_W'(1);
              stNext      = ST_RDATA;
            end else begin
              ctrl.relSda = 1'b1;
              stNext      = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      gotData <= 1'b0;
      ackSeen <= 1'b0;
    end else begin
      st      <= stNext;
      cnt     <= cntNext;
      gotData <= gotDataNext;
      ackSeen <= ackSeenNext;
    end
  end

  AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> (st == ST_IDLE)); // R9
  AST_MISS_TO_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_ADDR && cnt == FULL && sclFall && !addrHit && !stopDet && !startDet)
      |=> (st == ST_IDLE)); // R3
endmodule

// File: rtl/smbt_responder.sv
module smbt_responder
  import smbt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sclIn,
  input  logic                 sdaIn,
  input  logic [ADDR_W-1:0]    ownAddr,
  input  logic [BYTE_BITS-1:0] rdData,
  output logic                 sdaOeLow,
  output logic [BYTE_BITS-1:0] cmdByte,
  output logic                 cmdStb,
  output logic [BYTE_BITS-1:0] wrByte,
  output logic                 wrStb,
  output logic                 rdReq
);
  smbtCtrl_t ctrl;
  logic sclRise, sclFall, startDet, stopDet, sdaBit, addrHit;

  smbt_datapath #(.SYNC_STAGES(SYNC_STAGES)) uDp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .ownAddr(ownAddr),
    .rdData(rdData), .ctrl(ctrl), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .sdaBit(sdaBit), .addrHit(addrHit),
    .sdaOeLow(sdaOeLow), .cmdByte(cmdByte), .cmdStb(cmdStb), .wrByte(wrByte),
    .wrStb(wrStb), .rdReq(rdReq)
  );

  smbt_control uCtl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .sdaBit(sdaBit), .addrHit(addrHit),
    .ctrl(ctrl)
  );
endmodule

// File: tb/tb_smbt_responder.sv
module tb_smbt_responder;
  localparam int CLK_PERIOD = 10;
  localparam int QCLK = 8;

  logic clk = 1'b0, rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic [6:0] ownAddr = 7'h2C;
  logic [7:0] rdData = 8'h00;
  logic sdaOeLow, cmdStb, wrStb, rdReq;
  logic [7:0] cmdByte, wrByte;
  wire sdaLine = sdaM & ~sdaOeLow;

  int nChk = 0, nErr = 0;
  int cmdCnt = 0, wrCnt = 0, rdCnt = 0, driveCnt = 0, sclHighChg = 0;
  logic [7:0] wrLog [4];
  logic prevOe = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  smbt_responder dut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine), .ownAddr(ownAddr),
    .rdData(rdData), .sdaOeLow(sdaOeLow), .cmdByte(cmdByte), .cmdStb(cmdStb),
    .wrByte(wrByte), .wrStb(wrStb), .rdReq(rdReq)
  );

  always @(negedge clk) begin
    if (cmdStb) cmdCnt++;
    if (wrStb) begin
      wrLog[wrCnt % 4] = wrByte;
      wrCnt++;
    end
    if (rdReq) rdCnt++;
    if (sdaOeLow) driveCnt++;
    if (rstN && sdaOeLow != prevOe && sclM) sclHighChg++;
    prevOe = sdaOeLow;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hq();
    repeat (QCLK) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; sclM = 1'b1; hq();
    sdaM = 1'b0; hq();
    sclM = 1'b0; hq();
  endtask

  task automatic busRestart();
    sdaM = 1'b1; hq();
    sclM = 1'b1; hq();
    sdaM = 1'b0; hq();
    sclM = 1'b0; hq();
  endtask

  task automatic busStop();
    sdaM = 1'b0; hq();
    sclM = 1'b1; hq();
    sdaM = 1'b1; hq(); hq();
  endtask

  task automatic putBit(input logic b);
    sdaM = b; hq();
    sclM = 1'b1; hq(); hq();
    sclM = 1'b0; hq();
  endtask

  task automatic getBit(output logic v);
    sdaM = 1'b1; hq();
    sclM = 1'b1; hq();
    v = sdaLine; hq();
    sclM = 1'b0; hq();
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) putBit(b[i]);
    getBit(a);
    ack = ~a;
  endtask

  task automatic readByte(output logic [7:0] b, input logic mAck, input logic [7:0] nextRd);
    logic v;
    for (int i = 7; i >= 0; i--) begin
      getBit(v);
      b[i] = v;
    end
    sdaM = ~mAck; hq();
    sclM = 1'b1; hq();
    rdData = nextRd; hq();
    sclM = 1'b0; hq();
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    nChk++; nErr++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end

  initial begin : main
    logic ack, ack2;
    logic [7:0] rb;
    int c0, w0, r0, d0;
    repeat (3) @(negedge clk);
    chk(sdaOeLow == 1'b0, "R1 pull-down", sdaOeLow, 0);
    chk(!cmdStb && !wrStb && !rdReq, "R1 strobes", {cmdStb, wrStb, rdReq}, 0);
    rstN = 1'b1;
    hq();

    // R2/R3: every address, direction bit varied
    for (int a = 0; a < 128; a++) begin
      logic rw;
      rw = a[0] ^ a[3];
      d0 = driveCnt; c0 = cmdCnt;
      busStart();
      sendByte({a[6:0], rw}, ack);
      busStop();
      chk(ack == (a == 32'(ownAddr)), "R2 address match", ack, (a == 32'(ownAddr)));
      if (a != 32'(ownAddr))
        chk(driveCnt == d0 && cmdCnt == c0, "R3 no drive on miss", driveCnt - d0, 0);
    end

    // R2: other own addresses, both direction values
    foreach (rb[i]) begin end
    for (int k = 0; k < 4; k++) begin
      logic [6:0] oa;
      oa = (k == 0) ? 7'h00 : (k == 1) ? 7'h7F : (k == 2) ? 7'h55 : 7'h2A;
      ownAddr = oa;
      busStart(); sendByte({oa, 1'b1}, ack); busStop();
      chk(ack, "R2 match read-direction", ack, 1);
      busStart(); sendByte({oa ^ 7'h40, 1'b0}, ack); busStop();
      chk(!ack, "R2 top-bit neighbour", ack, 0);
    end
    ownAddr = 7'h2C;

    // R4/R5: command sweep with two write bytes
    for (int v = 0; v < 16; v++) begin
      logic [7:0] cv, d1, d2;
      cv = 8'(v * 17) ^ 8'h5A;
      d1 = ~cv;
      d2 = 8'(v * 3 + 1);
      c0 = cmdCnt; w0 = wrCnt;
      busStart();
      sendByte({ownAddr, 1'b0}, ack);
      sendByte(cv, ack2);
      chk(ack && ack2, "R4 command acknowledged", {ack, ack2}, 3);
      chk(cmdByte == cv && cmdCnt == c0 + 1, "R4 command byte", cmdByte, cv);
      sendByte(d1, ack);
      sendByte(d2, ack2);
      busStop();
      chk(ack && ack2, "R5 write acknowledged", {ack, ack2}, 3);
      chk(wrCnt == w0 + 2, "R5 write strobe count", wrCnt - w0, 2);
      chk(wrLog[w0 % 4] == d1 && wrLog[(w0 + 1) % 4] == d2, "R5 write bytes",
          wrLog[w0 % 4], d1);
    end

    // R6/R7/R8: two-byte read
    r0 = rdCnt;
    rdData = 8'h96;
    busStart();
    sendByte({ownAddr, 1'b0}, ack);
    sendByte(8'h11, ack);
    busRestart();
    sendByte({ownAddr, 1'b1}, ack);
    chk(ack, "R6 second address acknowledged", ack, 1);
    chk(rdCnt == r0 + 1, "R6 read request", rdCnt - r0, 1);
    readByte(rb, 1'b1, 8'h69);
    chk(rb == 8'h96, "R7 first read byte", rb, 8'h96);
    chk(rdCnt == r0 + 2, "R8 request after master ack", rdCnt - r0, 2);
    readByte(rb, 1'b0, 8'h00);
    chk(rb == 8'h69, "R8 second read byte", rb, 8'h69);
    chk(sdaOeLow == 1'b0, "R8 release after nack", sdaOeLow, 0);
    chk(rdCnt == r0 + 2, "R8 no request after nack", rdCnt - r0, 2);
    busStop();

    // R6: direction bit at 28 ignored
    r0 = rdCnt;
    rdData = 8'h3A;
    busStart();
    sendByte({ownAddr, 1'b0}, ack);
    sendByte(8'h22, ack);
    busRestart();
    sendByte({ownAddr, 1'b0}, ack);
    chk(ack && rdCnt == r0 + 1, "R6 write-direction second address", ack, 1);
    readByte(rb, 1'b0, 8'h00);
    chk(rb == 8'h3A, "R7 read byte", rb, 8'h3A);
    busStop();

    // R11: second-phase mismatch
    r0 = rdCnt; d0 = driveCnt;
    busStart();
    sendByte({ownAddr, 1'b0}, ack);
    sendByte(8'h33, ack);
    d0 = driveCnt;
    busRestart();
    sendByte({ownAddr ^ 7'h01, 1'b1}, ack);
    readByte(rb, 1'b0, 8'h00);
    busStop();
    chk(!ack, "R11 second mismatch nack", ack, 0);
    chk(rdCnt == r0 && driveCnt == d0 && rb == 8'hFF, "R11 no read", rdCnt - r0, 0);

    // R9: stop mid-command aborts
    c0 = cmdCnt;
    busStart();
    sendByte({ownAddr, 1'b0}, ack);
    putBit(1'b1); putBit(1'b0); putBit(1'b1); putBit(1'b1);
    busStop();
    chk(cmdCnt == c0 && sdaOeLow == 1'b0, "R9 abort without strobe", cmdCnt - c0, 0);
    busStart();
    sendByte({ownAddr, 1'b0}, ack);
    sendByte(8'hC7, ack2);
    busStop();
    chk(ack && ack2 && cmdByte == 8'hC7 && cmdCnt == c0 + 1, "R9 recovery", cmdByte, 8'hC7);

    chk(sclHighChg == 0, "R10 drive change while clock high", sclHighChg, 0);

    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end
endmodule